// File: doc/BRIEF.md
# Strap-Addressed I2C Instruction Target

This block is a 7-bit I2C target that takes its device address from a two-bit strap code. The code is decoded from a resistor setting on a configuration pin. Three of the four strap settings each select a different address. The fourth setting switches the bus interface off completely. In that case the target never drives SDA, and its instruction outputs are held at their default value of zero.

A write addressed to the target fills three 8-bit instruction registers in a fixed order. The target acknowledges those three bytes and refuses any byte that follows them. A read streams out diagnostic bytes, which a neighbouring latch block supplies according to a byte index. After each byte that the master acknowledges, the target sends a one-cycle done strobe carrying that byte's index, so the latch can clear the flags it has just reported.

SCL and SDA are sampled by the system clock through a short synchronizer. Every bus event is found by comparing successive samples, so the block runs entirely in the system clock domain. The SDA output is an open-drain pull-down enable.

Top module: `strap_i2c_target`

## Requirements
- R1: After a synchronous reset, all three instruction outputs read 0x00, the SDA pull-down is released, and no strobe is active.
- R2: The device address is selected by the strap code: 2'b00 gives 7'b1101100, 2'b01 gives 7'b1101101 and 2'b10 gives 7'b1101111. Only a matching address is acknowledged, by pulling SDA low during the ninth clock. The eighth bit after the address is read/write, where 0 means write and 1 means read.
- R3: With strap code 2'b11, the block never pulls SDA and never acknowledges anything. All three instruction outputs read 0x00, including bit 0 of the first register, which has no meaning in this setting. The registers stay cleared when a live code returns.
- R4: In a matching write, the first three data bytes are received MSB first. They are stored in order into the first, second and third instruction outputs, and each of them is acknowledged.
- R5: Data bytes after the third one in a write are not acknowledged, and they leave all three instruction outputs unchanged.
- R6: In a matching read, the target sends diag_data_i MSB first, as seen while rd_idx_o holds the index of the byte being sent. The index starts at 0 for every address phase and advances modulo DIAG_BYTES after each byte the master acknowledges. rd_req_o pulses for one cycle, with rd_idx_o valid, each time a byte is captured for sending.
- R7: When the master acknowledges a read byte, rd_done_o pulses for exactly one cycle and rd_done_idx_o carries that byte's index. When the master does not acknowledge a byte, there is no strobe and the target stops driving SDA.
- R8: A STOP in the middle of a byte throws away the partial byte and returns the target to idle. A repeated START in the middle of a byte also throws away the partial byte and begins a new address phase. Bytes already completed keep the values they were given.
- R9: The SDA pull-down enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| strap_i | input | 2 | Decoded strap code: 00, 01 and 10 select an address, 11 disables the bus |
| diag_data_i | input | 8 | Diagnostic byte for the index shown on rd_idx_o |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| ib1_o | output | 8 | First instruction register |
| ib2_o | output | 8 | Second instruction register |
| ib3_o | output | 8 | Third instruction register |
| rd_req_o | output | 1 | One-cycle pulse when a read byte is captured |
| rd_idx_o | output | clog2(DIAG_BYTES) (2) | Index of the diagnostic byte being requested |
| rd_done_o | output | 1 | One-cycle pulse after the master acknowledges a read byte |
| rd_done_idx_o | output | clog2(DIAG_BYTES) (2) | Index of the byte that was acknowledged |

## Verification
Each bus edge passes two synchronizer flops and one edge-detect compare, and the state machine adds one register after that. A pull-down change, a register write or a strobe therefore appears about three system clocks after the SCL edge that causes it. The bench sets SDA three clocks after SCL falls and samples SDA in the middle of a ten-clock SCL high phase, so acknowledge bits and read bits are taken well after they have settled. Instruction registers are compared only after the STOP, and strobes are logged on falling clock edges throughout each transfer, then compared with the expected index sequence once the transfer has ended.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int NUM_IB   = 3;
    localparam int IB_IDX_W = $clog2(NUM_IB + 1);

    typedef enum logic [1:0] {
        STRAP_OPEN = 2'd0,
        STRAP_R51K = 2'd1,
        STRAP_R10K = 2'd2,
        STRAP_GND  = 2'd3
    } strap_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tgt_state_e;

    // Synchronized line levels plus the events found between two samples.
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // One instruction register write request.
    typedef struct packed {
        logic                  we;
        logic [IB_IDX_W-1:0]   idx;
        logic [BYTE_W-1:0]     data;
    } ib_wr_t;

    function automatic logic [ADDR_W-1:0] strap_addr(input strap_e s);
        case (s)
            STRAP_OPEN: return 7'b1101100;
            STRAP_R51K: return 7'b1101101;
            STRAP_R10K: return 7'b1101111;
            default:    return '0;
        endcase
    endfunction

    function automatic logic strap_live(input strap_e s);
        return s != STRAP_GND;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import strap_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_d;
    logic                   sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
            scl_d <= scl_q[LAST];
            sda_d <= sda_q[LAST];
        end
    end

    always_comb begin
        evt.scl      = scl_q[LAST];
        evt.sda      = sda_q[LAST];
        evt.scl_rise = scl_q[LAST] & ~scl_d;
        evt.scl_fall = ~scl_q[LAST] & scl_d;
        evt.start    = scl_q[LAST] & scl_d & sda_d & ~sda_q[LAST];
        evt.stop     = scl_q[LAST] & scl_d & ~sda_d & sda_q[LAST];
    end

endmodule

// File: rtl/ib_regfile.sv
module ib_regfile
    import strap_i2c_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  ib_wr_t                        wr,
    output logic [NUM_IB-1:0][BYTE_W-1:0] ib_q
);

    for (genvar g = 0; g < NUM_IB; g++) begin : g_ib
        logic [BYTE_W-1:0] val;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                val <= '0;
            end else if (wr.we && (wr.idx == IB_IDX_W'(g))) begin
                val <= wr.data;
            end
        end

        assign ib_q[g] = val;
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import strap_i2c_pkg::*;
#(
    parameter int DIAG_BYTES = 4,
    parameter int RD_IDX_W   = $clog2(DIAG_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [ADDR_W-1:0]    my_addr,
    input  bus_evt_t             evt,
    input  logic [BYTE_W-1:0]    diag_data_i,
    output logic                 sda_pull,
    output logic                 rd_req,
    output logic [RD_IDX_W-1:0]  rd_idx,
    output logic                 rd_done,
    output logic [RD_IDX_W-1:0]  rd_done_idx,
    output ib_wr_t               ib_wr
);
    localparam logic [3:0]          BITS_FULL = 4'd8;
    localparam logic [RD_IDX_W-1:0] IDX_LAST  = RD_IDX_W'(DIAG_BYTES - 1);

    tgt_state_e          state;
    logic [3:0]          bitcnt;
    logic [BYTE_W-1:0]   shreg;
    logic                rw;
    logic [IB_IDX_W-1:0] wr_idx;

    function automatic logic [RD_IDX_W-1:0] idx_next(input logic [RD_IDX_W-1:0] i);
        return (i == IDX_LAST) ? '0 : i + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state       <= ST_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            rw          <= 1'b0;
            wr_idx      <= '0;
            rd_idx      <= '0;
            rd_done_idx <= '0;
            sda_pull    <= 1'b0;
            rd_req      <= 1'b0;
            rd_done     <= 1'b0;
            ib_wr       <= '0;
        end else begin
            rd_req   <= 1'b0;
            rd_done  <= 1'b0;
            ib_wr.we <= 1'b0;
            if (evt.start) begin
                // a fresh or repeated START always opens an address phase
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
                wr_idx   <= '0;
                rd_idx   <= '0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall && bitcnt == BITS_FULL) begin
                            if (shreg[BYTE_W-1:1] == my_addr) begin
                                rw       <= shreg[0];
                                sda_pull <= 1'b1;
                                state    <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg    <= diag_data_i;
                                sda_pull <= ~diag_data_i[BYTE_W-1];
                                rd_req   <= 1'b1;
                                state    <= ST_RD;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall && bitcnt == BITS_FULL) begin
                            if (wr_idx < IB_IDX_W'(NUM_IB)) begin
                                ib_wr.we   <= 1'b1;
                                ib_wr.idx  <= wr_idx;
                                ib_wr.data <= shreg;
                                sda_pull   <= 1'b1;
                            end
                            state <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            if (wr_idx < IB_IDX_W'(NUM_IB)) begin
                                wr_idx <= wr_idx + 1'b1;
                            end
                            state <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (bitcnt == BITS_FULL) begin
                                sda_pull <= 1'b0;
                                state    <= ST_RD_ACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            if (!evt.sda) begin
                                rd_done     <= 1'b1;
                                rd_done_idx <= rd_idx;
                                rd_idx      <= idx_next(rd_idx);
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (evt.scl_fall) begin
                            bitcnt   <= '0;
                            shreg    <= diag_data_i;
                            sda_pull <= ~diag_data_i[BYTE_W-1];
                            rd_req   <= 1'b1;
                            state    <= ST_RD;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
    import strap_i2c_pkg::*;
#(
    parameter int DIAG_BYTES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scl_i,
    input  logic                          sda_i,
    input  logic [1:0]                    strap_i,
    input  logic [7:0]                    diag_data_i,
    output logic                          sda_pull_o,
    output logic [7:0]                    ib1_o,
    output logic [7:0]                    ib2_o,
    output logic [7:0]                    ib3_o,
    output logic                          rd_req_o,
    output logic [$clog2(DIAG_BYTES)-1:0] rd_idx_o,
    output logic                          rd_done_o,
    output logic [$clog2(DIAG_BYTES)-1:0] rd_done_idx_o
);
    localparam int RD_IDX_W = $clog2(DIAG_BYTES);

    strap_e                        strap;
    logic                          bus_live;
    logic [ADDR_W-1:0]             my_addr;
    bus_evt_t                      evt;
    ib_wr_t                        ib_wr;
    logic [NUM_IB-1:0][BYTE_W-1:0] ib_q;
    logic                          scl_sync;

    assign strap    = strap_e'(strap_i);
    assign bus_live = strap_live(strap);
    assign my_addr  = strap_addr(strap);
    assign scl_sync = evt.scl;

    i2c_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_target_fsm #(
        .DIAG_BYTES (DIAG_BYTES),
        .RD_IDX_W   (RD_IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .en          (bus_live),
        .my_addr     (my_addr),
        .evt         (evt),
        .diag_data_i (diag_data_i),
        .sda_pull    (sda_pull_o),
        .rd_req      (rd_req_o),
        .rd_idx      (rd_idx_o),
        .rd_done     (rd_done_o),
        .rd_done_idx (rd_done_idx_o),
        .ib_wr       (ib_wr)
    );

    ib_regfile u_regs (
        .clk  (clk),
        .rst  (rst),
        .clr  (!bus_live),
        .wr   (ib_wr),
        .ib_q (ib_q)
    );

    assign ib1_o = ib_q[0];
    assign ib2_o = ib_q[1];
    assign ib3_o = ib_q[2];

endmodule

// File: rtl/strap_i2c_target_chk.sv
module strap_i2c_target_chk #(
    parameter int DIAG_BYTES = 4,
    parameter int RD_IDX_W   = $clog2(DIAG_BYTES)
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          strap_i,
    input logic                scl_sync,
    input logic                sda_pull_o,
    input logic [7:0]          ib1_o,
    input logic [7:0]          ib2_o,
    input logic [7:0]          ib3_o,
    input logic                rd_done_o,
    input logic [RD_IDX_W-1:0] rd_idx_o,
    input logic [RD_IDX_W-1:0] rd_done_idx_o
);
    localparam logic [RD_IDX_W-1:0] IDX_LAST = RD_IDX_W'(DIAG_BYTES - 1);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ib1_o == 8'h00 && ib2_o == 8'h00 && ib3_o == 8'h00 && !sda_pull_o)); // R1

    AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (strap_i == 2'b11 && $past(strap_i) == 2'b11)
            |-> (!sda_pull_o && ib1_o == 8'h00 && ib2_o == 8'h00 && ib3_o == 8'h00)); // R3

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pull_o) && $stable(strap_i)) |-> !$past(scl_sync)); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_done_o |=> !rd_done_o); // R7

    AST_DONE_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        rd_done_o |-> (rd_idx_o == ((rd_done_idx_o == IDX_LAST) ? '0 : rd_done_idx_o + 1'b1))); // R6

endmodule

bind strap_i2c_target strap_i2c_target_chk #(
    .DIAG_BYTES (DIAG_BYTES)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .strap_i       (strap_i),
    .scl_sync      (scl_sync),
    .sda_pull_o    (sda_pull_o),
    .ib1_o         (ib1_o),
    .ib2_o         (ib2_o),
    .ib3_o         (ib3_o),
    .rd_done_o     (rd_done_o),
    .rd_idx_o      (rd_idx_o),
    .rd_done_idx_o (rd_done_idx_o)
);

// File: tb/strap_i2c_target_tb_top.sv
`timescale 1ns/1ps
module strap_i2c_target_tb_top;

    localparam int HP = 10;   // system clocks per SCL phase
    localparam int Q  = 3;    // delay after SCL falls before SDA is changed
    localparam int ND = 4;    // diagnostic bytes

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_line;
    logic [7:0] diag_data;
    logic       sda_pull_o;
    logic [7:0] ib1_o, ib2_o, ib3_o;
    logic       rd_req_o, rd_done_o;
    logic [1:0] rd_idx_o, rd_done_idx_o;

    logic [7:0] diag_mem [ND];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic [7:0] exp_ib [3];
    int         cur_strap = 0;
    int         vectors = 0;
    int         miscompares = 0;
    int         req_cnt = 0, done_cnt = 0, r9_viol = 0;
    int         req_log [16];
    int         done_log [16];
    logic       pull_prev = 1'b0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    assign sda_line  = m_sda & ~sda_pull_o;
    assign diag_data = diag_mem[rd_idx_o];

    strap_i2c_target #(.DIAG_BYTES(ND), .SYNC_STAGES(2)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (m_scl),
        .sda_i         (sda_line),
        .strap_i       (strap),
        .diag_data_i   (diag_data),
        .sda_pull_o    (sda_pull_o),
        .ib1_o         (ib1_o),
        .ib2_o         (ib2_o),
        .ib3_o         (ib3_o),
        .rd_req_o      (rd_req_o),
        .rd_idx_o      (rd_idx_o),
        .rd_done_o     (rd_done_o),
        .rd_done_idx_o (rd_done_idx_o)
    );

    // strobe logging and the R9 pull-change monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_req_o) begin
                req_log[req_cnt % 16] = int'(rd_idx_o);
                req_cnt++;
            end
            if (rd_done_o) begin
                done_log[done_cnt % 16] = int'(rd_done_idx_o);
                done_cnt++;
            end
            if (sda_pull_o != pull_prev && m_scl) r9_viol++;
            pull_prev = sda_pull_o;
        end
    end

    function automatic logic [6:0] exp_addr(input int s);
        case (s)
            0: return 7'b1101100;
            1: return 7'b1101101;
            2: return 7'b1101111;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check({req, " ib1"}, 32'(ib1_o), 32'(exp_ib[0]));
        check({req, " ib2"}, 32'(ib2_o), 32'(exp_ib[1]));
        check({req, " ib3"}, 32'(ib3_o), 32'(exp_ib[2]));
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        wait_n(Q);
        m_sda = b;
        wait_n(HP - Q);
        m_scl = 1'b1;
        wait_n(HP / 2);
        r = sda_line;
        wait_n(HP - HP / 2);
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        wait_n(Q);
        m_sda = 1'b1;
        wait_n(HP - Q);
        m_scl = 1'b1;
        wait_n(HP);
        m_sda = 1'b0;
        wait_n(HP);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(Q);
        m_sda = 1'b0;
        wait_n(HP - Q);
        m_scl = 1'b1;
        wait_n(HP);
        m_sda = 1'b1;
        wait_n(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic r;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, r);
            b = {b[6:0], r};
        end
        clk_bit(!mack, r);
    endtask

    task automatic set_strap(input int s);
        cur_strap = s;
        strap = 2'(s);
        wait_n(4);
        if (s == 3) for (int i = 0; i < 3; i++) exp_ib[i] = 8'h00;
    endtask

    task automatic run_write(input logic [6:0] a, input int n);
        logic aack, ak;
        bit   hit;
        hit = (cur_strap != 3) && (a == exp_addr(cur_strap));
        bus_start();
        send_byte({a, 1'b0}, aack);
        check(cur_strap == 3 ? "R3 legacy address nack" : "R2 write address ack",
              32'(aack), 32'(hit));
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ak);
            if (hit) begin
                check(i < 3 ? "R4 data byte ack" : "R5 extra byte nack", 32'(ak), 32'(i < 3));
                if (i < 3) exp_ib[i] = wbuf[i];
            end else begin
                check(cur_strap == 3 ? "R3 legacy data nack" : "R2 foreign data nack", 32'(ak), 0);
            end
        end
        bus_stop();
        wait_n(4);
        check_regs(n > 3 ? "R5 registers" : (cur_strap == 3 ? "R3 registers" : "R4 registers"));
    endtask

    task automatic run_read(input logic [6:0] a, input int n);
        logic aack;
        logic [7:0] b;
        bit hit;
        hit = (cur_strap != 3) && (a == exp_addr(cur_strap));
        req_cnt = 0;
        done_cnt = 0;
        bus_start();
        send_byte({a, 1'b1}, aack);
        check(cur_strap == 3 ? "R3 legacy read nack" : "R2 read address ack", 32'(aack), 32'(hit));
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        bus_stop();
        wait_n(4);
        if (hit) begin
            for (int i = 0; i < n; i++) begin
                check("R6 read data", 32'(rbuf[i]), 32'(diag_mem[i % ND]));
                check("R6 request index", 32'(req_log[i]), 32'(i % ND));
            end
            check("R6 request count", 32'(req_cnt), 32'(n));
            check("R7 done count", 32'(done_cnt), 32'(n - 1));
            for (int i = 0; i < n - 1; i++)
                check("R7 done index", 32'(done_log[i]), 32'(i % ND));
        end else begin
            check("R6 no request", 32'(req_cnt), 0);
            check("R7 no done", 32'(done_cnt), 0);
        end
    endtask

    task automatic fill_diag();
        for (int i = 0; i < ND; i++) diag_mem[i] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 3; i++) exp_ib[i] = 8'h00;
        fill_diag();
        wait_n(5);
        rst = 1'b0;
        wait_n(3);
        check("R1 reset ib1", 32'(ib1_o), 0);
        check("R1 reset ib2", 32'(ib2_o), 0);
        check("R1 reset ib3", 32'(ib3_o), 0);
        check("R1 reset pull", 32'(sda_pull_o), 0);
        check("R1 reset strobes", 32'({rd_req_o, rd_done_o}), 0);

        // R2 R4: each live strap setting takes its own address
        set_strap(0);
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
        run_write(7'b1101100, 3);
        set_strap(1);
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h18;
        run_write(7'b1101101, 3);
        set_strap(2);
        wbuf[0] = 8'hFF; wbuf[1] = 8'h00;
        run_write(7'b1101100, 2);      // foreign address, ignored (R2)
        // R5: bytes past the third
        wbuf[0] = 8'h01; wbuf[1] = 8'h80; wbuf[2] = 8'h7E; wbuf[3] = 8'hEE; wbuf[4] = 8'h99;
        run_write(7'b1101111, 5);

        // R6 R7: reads, including index wrap
        fill_diag();
        run_read(7'b1101111, 3);
        fill_diag();
        run_read(7'b1101111, 6);
        run_read(7'b1101101, 2);       // foreign address read

        // R8: STOP mid-byte
        set_strap(0);
        begin
            logic ak, r;
            bus_start();
            send_byte({7'b1101100, 1'b0}, ak);
            send_byte(8'h11, ak);
            check("R8 first byte ack", 32'(ak), 1);
            clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b1, r);
            bus_stop();
            wait_n(4);
            exp_ib[0] = 8'h11;
            check_regs("R8 stop mid-byte");
            // R8: repeated START mid-address
            bus_start();
            clk_bit(1'b1, r); clk_bit(1'b1, r); clk_bit(1'b0, r);
            bus_start();
            send_byte({7'b1101100, 1'b0}, ak);
            check("R8 address after repeated start", 32'(ak), 1);
            send_byte(8'h22, ak);
            check("R8 byte after repeated start", 32'(ak), 1);
            bus_stop();
            wait_n(4);
            exp_ib[0] = 8'h22;
            check_regs("R8 repeated start");
        end

        // R3: legacy setting
        set_strap(3);
        check_regs("R3 legacy clear");
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
        run_write(7'b1101100, 3);
        run_read(7'b1101100, 2);
        set_strap(0);
        check_regs("R3 cleared after legacy");

        // constrained random mix
        for (int it = 0; it < 24; it++) begin
            int s, n;
            logic [6:0] a;
            s = int'($urandom % 3);
            set_strap(s);
            a = ($urandom % 5 == 0) ? 7'($urandom) : exp_addr(s);
            if ($urandom % 2 == 0) begin
                n = 1 + int'($urandom % 5);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                run_write(a, n);
            end else begin
                n = 1 + int'($urandom % 6);
                fill_diag();
                run_read(a, n);
            end
        end

        check("R9 pull changed while SCL high", 32'(r9_viol), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule